// File: doc/BRIEF.md
# Bridge Control Register File

This block is a bank of 28 word-wide control registers for a host bridge. The registers sit at byte offsets 0x00 through 0x6C. They hold configuration, general-purpose I/O, interrupt-controller, mailbox, cache and timing settings. Software reaches them over a plain register bus that has an address, a write strobe, write data and read data. Every access is a full 32-bit word. A read returns its data in the same cycle, and a write takes effect at the next clock edge.

Three words do more than store data. The interrupt enable word cannot be written directly. It changes only through two alias words: one ORs the written bits into the enable word, and the other clears them. The general-configuration word watches its bit 2. A write that takes this bit from 0 to 1 produces a one-cycle system-reset request. The block does not act on the meaning of any other configuration field.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset, the words read as follows. 0x00 reads 0x00000C40, 0x04 reads 0x00001384, 0x08 reads 0x2BFF8010, 0x0C reads 0x255E0091, 0x10 reads 0x00006140, 0x1C and 0x20 read 0x000001FF, 0x68 reads 0x00000008 and 0x6C reads 0x10000000. Every other mapped word reads zero.
- R2: A write to 0x00, to 0x08 through 0x2C, or to 0x40 through 0x6C stores all 32 bits. A later read of that offset returns the stored value.
- R3: A write to 0x30 stores the value, which then reads back at 0x30. The same write ORs the value into the enable word at 0x38.
- R4: A write to 0x34 stores the value, which then reads back at 0x34. The same write clears, in the enable word at 0x38, every bit that is 1 in the value.
- R5: Writes to 0x38 and 0x3C change nothing. The status word at 0x3C always reads zero.
- R6: Take a write to 0x04 whose bit 2 is 1 while the stored bit 2 is 0. In the cycle after that write edge, `rst_req` is high for exactly one cycle. The value is stored.
- R7: A write to 0x04 stores its value but gives no request in two cases: the stored bit 2 is already 1, or the written bit 2 is 0. `rst_req` is never high for two cycles in a row.
- R8: Some accesses fall outside the map: offsets 0x70 through 0x7C, and any offset whose low two bits are not 00. A write there changes no register, and a read there returns zero.
- R9: `rdata` shows the word selected by `addr` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 7 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench goes after four corner cases.
- The reset value of bit 2 in the general-configuration word is already 1. A design that fired on the level of the written bit, instead of on its 0-to-1 change, would give a request on the first write.
- Set and clear writes are interleaved on overlapping bit patterns. A design that let the enable word be written directly, or that applied the raw value instead of an OR or an AND-NOT, would read back a wrong 0x38.
- Misaligned offsets are written. A design that decoded only the word index would store the misaligned data.
- Offsets past 0x6C are written. A design that wrapped the index would corrupt a low register.

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs #(
  parameter int DW   = 32,
  parameter int AW   = 7,
  parameter int NREG = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rst_req
);
  localparam int IW      = AW - 2;
  localparam int GEN_IX  = 1;
  localparam int SET_IX  = 12;
  localparam int CLR_IX  = 13;
  localparam int EN_IX   = 14;
  localparam int STAT_IX = 15;
  localparam int RST_BIT = 2;

  function automatic logic [DW-1:0] init_val(int i);
    case (i)
      0:       return DW'(32'h0000_0C40);
      1:       return DW'(32'h0000_1384);
      2:       return DW'(32'h2BFF_8010);
      3:       return DW'(32'h255E_0091);
      4:       return DW'(32'h0000_6140);
      7, 8:    return DW'(32'h0000_01FF);
      26:      return DW'(32'h0000_0008);
      27:      return DW'(32'h1000_0000);
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] idx;
  logic          mapped;
  logic          wr_ok;

  assign idx    = addr[AW-1:2];
  assign mapped = (addr[1:0] == 2'b00) && (int'(idx) < NREG);
  assign wr_ok  = wr_en && mapped;
  assign rdata  = mapped ? regs[idx] : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == EN_IX) begin : g_en
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          regs[i] <= init_val(i);
        else if (wr_ok && idx == IW'(SET_IX))
          regs[i] <= regs[i] | wdata;
        else if (wr_ok && idx == IW'(CLR_IX))
          regs[i] <= regs[i] & ~wdata;
    end else if (i == STAT_IX) begin : g_stat
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          regs[i] <= init_val(i);
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          regs[i] <= init_val(i);
        else if (wr_ok && idx == IW'(i))
          regs[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      rst_req <= 1'b0;
    else
      rst_req <= wr_ok && idx == IW'(GEN_IX) && !regs[GEN_IX][RST_BIT] && wdata[RST_BIT];
endmodule

// File: rtl/bridge_ctrl_regs_chk.sv
module bridge_ctrl_regs_chk #(
  parameter int DW = 32,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] gen_q,
  input logic [DW-1:0] en_q,
  input logic          rst_req
);
  logic set_wr, clr_wr;
  assign set_wr = wr_en && addr == AW'(8'h30);
  assign clr_wr = wr_en && addr == AW'(8'h34);

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> (en_q & $past(wdata)) == $past(wdata)); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (en_q & $past(wdata)) == '0); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr || clr_wr) |=> $stable(en_q)); // R5
  AST_RSTREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wr_en && addr == AW'(8'h04) && wdata[2] && !gen_q[2])); // R6
  AST_RSTREQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[1:0] != 2'b00 || addr[AW-1:2] >= (AW-2)'(28)) |-> rdata == '0); // R8
endmodule

bind bridge_ctrl_regs bridge_ctrl_regs_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .gen_q(regs[1]), .en_q(regs[14]), .rst_req(rst_req)
);

// File: tb/bridge_ctrl_regs_tb.sv
`timescale 1ns/1ps
module bridge_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] mem [32];
  logic        exp_req = 1'b0;

  always #10 clk = ~clk;

  bridge_ctrl_regs u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                          .wdata(wdata), .rdata(rdata), .rst_req(rst_req));

  function automatic logic [31:0] m_read(logic [6:0] a);
    if (a[1:0] != 2'b00 || a[6:2] >= 5'd28) return 32'h0;
    return mem[a[6:2]];
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
    mem[0] = 32'hC40;      mem[1] = 32'h1384;   mem[2] = 32'h2BFF8010;
    mem[3] = 32'h255E0091; mem[4] = 32'h6140;   mem[7] = 32'h1FF;
    mem[8] = 32'h1FF;      mem[26] = 32'h8;     mem[27] = 32'h10000000;
    exp_req = 1'b0;
  endtask

  task automatic m_write(logic [6:0] a, logic [31:0] d);
    int ix;
    exp_req = 1'b0;
    if (a[1:0] != 2'b00 || a[6:2] >= 5'd28) return;
    ix = int'(a[6:2]);
    case (ix)
      1:  begin exp_req = !mem[1][2] && d[2]; mem[1] = d; end
      12: begin mem[12] = d; mem[14] = mem[14] | d; end
      13: begin mem[13] = d; mem[14] = mem[14] & ~d; end
      14, 15: ;
      default: mem[ix] = d;
    endcase
  endtask

  task automatic cyc(logic we, logic [6:0] a, logic [31:0] d, string tag, string rtag = "R7");
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    #8;
    nchk++;
    if (rdata !== m_read(a)) begin
      nfail++;
      $display("FAIL %s rdata @%h: got %h expected %h", tag, a, rdata, m_read(a));
    end
    nchk++;
    if (rst_req !== exp_req) begin
      nfail++;
      $display("FAIL %s rst_req: got %b expected %b", rtag, rst_req, exp_req);
    end
    @(posedge clk);
    if (we) m_write(a, d); else exp_req = 1'b0;
  endtask

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 32; i++) cyc(1'b0, 7'(i * 4), 32'h0, i < 28 ? "R1" : "R8");
    for (int i = 0; i < 28; i++)
      if (!(i == 1 || (i >= 12 && i <= 15)))
        cyc(1'b1, 7'(i * 4), 32'hA5000000 ^ (32'h01010101 * i), "R2");
    for (int i = 0; i < 28; i++) cyc(1'b0, 7'(i * 4), 32'h0, "R9");
    cyc(1'b1, 7'h30, 32'h0000_00F3, "R3");
    cyc(1'b0, 7'h38, 32'h0, "R3");
    cyc(1'b1, 7'h30, 32'h8000_0100, "R3");
    cyc(1'b0, 7'h30, 32'h0, "R3");
    cyc(1'b1, 7'h34, 32'h0000_0031, "R4");
    cyc(1'b0, 7'h38, 32'h0, "R4");
    cyc(1'b0, 7'h34, 32'h0, "R4");
    cyc(1'b1, 7'h34, 32'hFFFF_FFFF, "R4");
    cyc(1'b0, 7'h38, 32'h0, "R4");
    cyc(1'b1, 7'h30, 32'h0F0F_0F0F, "R3");
    cyc(1'b1, 7'h38, 32'hFFFF_FFFF, "R5");
    cyc(1'b1, 7'h3C, 32'hDEAD_BEEF, "R5");
    cyc(1'b0, 7'h38, 32'h0, "R5");
    cyc(1'b0, 7'h3C, 32'h0, "R5");
    cyc(1'b1, 7'h04, 32'h0000_1384, "R7", "R7");
    cyc(1'b0, 7'h04, 32'h0, "R7", "R7");
    cyc(1'b1, 7'h04, 32'h0000_0000, "R7", "R7");
    cyc(1'b1, 7'h04, 32'h0000_0004, "R6", "R6");
    cyc(1'b0, 7'h04, 32'h0, "R6", "R6");
    cyc(1'b0, 7'h04, 32'h0, "R6", "R7");
    cyc(1'b1, 7'h04, 32'h0000_0000, "R6", "R6");
    cyc(1'b1, 7'h04, 32'hFFFF_FFFF, "R6", "R6");
    cyc(1'b1, 7'h04, 32'hFFFF_FFFF, "R7", "R6");
    cyc(1'b0, 7'h04, 32'h0, "R7", "R7");
    cyc(1'b1, 7'h41, 32'h1234_5678, "R8");
    cyc(1'b1, 7'h42, 32'h1234_5678, "R8");
    cyc(1'b1, 7'h03, 32'h1234_5678, "R8");
    cyc(1'b0, 7'h40, 32'h0, "R8");
    cyc(1'b0, 7'h00, 32'h0, "R8");
    for (int i = 28; i < 32; i++) cyc(1'b1, 7'(i * 4), 32'hCAFE_0000 + 32'(i), "R8");
    for (int i = 0; i < 32; i++) cyc(1'b0, 7'(i * 4), 32'h0, i < 28 ? "R9" : "R8");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule